// File: doc/BRIEF.md
# Packet Receive Port with Valid Latch

This block is the PHY-side receive port of a byte-wide packet interface. Upstream logic writes tagged bytes into a small internal FIFO. Each byte carries start, end and error tags. A packet-layer device drains the FIFO on a clock it supplies. The device drives an active-low read enable and a port-select level. The port answers with the data byte, the framing flags, odd parity and a valid flag.

The valid flag drops when the last byte of a packet has been handed over, or when a read finds the FIFO empty. After it drops it stays low, even if more bytes are waiting, until the device deselects the port and selects it again. This lets the packet layer treat each selection as at most one packet.

A one-cycle arrival pulse marks each accepted start-of-packet write. The gap between that pulse and the matching start flag on the read side gives the FIFO latency.

Top module: `posrx_port`

## Requirements
- R1: After reset the valid flag and the arrival pulse are low, the FIFO is empty and the port is unselected and ready to stream on its first selection.
- R2: When the port is selected (portSel high), readEnN is low at a clock edge, the FIFO is not empty and the port has not halted, the oldest byte is popped. Its data, start and end flags appear with rxVal high in the following cycle.
- R3: While readEnN is high, nothing is popped and every output holds its value.
- R4: After the byte tagged end-of-packet has been presented, the next enabled cycle drives rxVal low and pops nothing, even when more bytes are stored. rxVal stays low until portSel goes low and high again. The next byte is then delivered in FIFO order.
- R5: An enabled read on an empty FIFO drives rxVal low. rxVal stays low, with no pop, until a deselect followed by a reselect, even if bytes are written meanwhile.
- R6: While portSel is low, rxVal is low at every following edge and no byte is popped, whatever readEnN does.
- R7: rxErr is high only on a byte that also carries rxEop. An error tag on a byte without the end tag is dropped.
- R8: rxPar is odd parity over rxData: the count of ones in {rxData, rxPar} is odd.
- R9: tsPulse is high for exactly one cycle, in the cycle after a write with the start tag set is accepted.
- R10: The FIFO stores 16 entries. A write while 16 are stored is dropped. Stored bytes come out in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the packet layer |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Write strobe into the receive FIFO |
| wrData | input | 8 | Byte to store |
| wrSop | input | 1 | Start-of-packet tag of the written byte |
| wrEop | input | 1 | End-of-packet tag of the written byte |
| wrErr | input | 1 | Error tag (abort or bad check sequence) of the written byte |
| readEnN | input | 1 | Read enable, active low |
| portSel | input | 1 | High while the packet layer has this port selected |
| rxData | output | 8 | Byte presented to the packet layer |
| rxSop | output | 1 | Start-of-packet flag |
| rxEop | output | 1 | End-of-packet flag, marks the last byte |
| rxErr | output | 1 | Packet error flag, only with rxEop |
| rxPar | output | 1 | Odd parity over rxData |
| rxVal | output | 1 | Outputs are meaningful while high |
| tsPulse | output | 1 | One-cycle pulse when a start-of-packet byte enters the FIFO |

## Verification
The bench places a second packet behind the first and checks that the valid flag stays low after the end byte. A design that resumed on the next available word would leak the second packet into the same selection. It also reads an empty FIFO, writes a byte, and checks that the byte is held back until a reselect. A design that recovered by itself would present it early. Holding read enable high with valid set must not skip a byte, which catches a pop that ignores the enable. A 17th write into a full FIFO must vanish without disturbing order, which catches pointer wrap and overflow slips. The error tag on a non-end byte must not reach the output.

// File: rtl/posrx_pkg.sv
package posrx_pkg;

  localparam int DATA_W = 8;

  // One FIFO entry: payload byte plus framing and error tags.
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              err;
  } rxWord_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic pop;   // take the head entry and load the output registers
  } rxStrb_t;

  // Read-side port state.
  typedef enum logic [1:0] {
    PS_DESEL  = 2'd0,
    PS_STREAM = 2'd1,
    PS_HALT   = 2'd2
  } portState_t;

endpackage

// File: rtl/posrx_dp.sv
module posrx_dp
  import posrx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  rxWord_t           wrWord,
  input  rxStrb_t           strb,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              headEop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSop,
  output logic              rxEop,
  output logic              rxErr,
  output logic              rxPar,
  output logic              tsPulse
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  rxWord_t       mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] level;
  rxWord_t       headWord;
  logic          doPush;
  logic          doPop;

  assign fifoFull  = (level == FULL_LVL);
  assign fifoEmpty = (level == '0);
  assign doPush    = wrValid & ~fifoFull;
  assign doPop     = strb.pop & ~fifoEmpty;
  assign headWord  = mem[rdPtr];
  assign headEop   = headWord.eop;

  // Storage: no reset needed, pointers and level qualify it.
  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      end
      unique case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // Output register stage: loads only on a pop, otherwise holds.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxSop  <= 1'b0;
      rxEop  <= 1'b0;
      rxErr  <= 1'b0;
      rxPar  <= 1'b1;
    end else if (doPop) begin
      rxData <= headWord.data;
      rxSop  <= headWord.sop;
      rxEop  <= headWord.eop;
      rxErr  <= headWord.err & headWord.eop;
      rxPar  <= ~^headWord.data;
    end
  end

  // Arrival marker for latency measurement.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsPulse <= 1'b0;
    end else begin
      tsPulse <= doPush & wrWord.sop;
    end
  end

endmodule

// File: rtl/posrx_ctrl.sv
module posrx_ctrl
  import posrx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    readEnN,
  input  logic    portSel,
  input  logic    fifoEmpty,
  input  logic    headEop,
  output rxStrb_t strb,
  output logic    rxVal
);

  portState_t state;
  portState_t stateNxt;
  logic       readReq;
  logic       canPop;

  assign readReq  = portSel & ~readEnN;
  assign canPop   = readReq & (state != PS_HALT) & ~fifoEmpty;
  assign strb.pop = canPop;

  always_comb begin
    stateNxt = state;
    if (!portSel) begin
      stateNxt = PS_DESEL;
    end else if (readReq && state != PS_HALT) begin
      if (fifoEmpty || headEop) begin
        stateNxt = PS_HALT;
      end else begin
        stateNxt = PS_STREAM;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_DESEL;
      rxVal <= 1'b0;
    end else begin
      state <= stateNxt;
      if (!portSel) begin
        rxVal <= 1'b0;
      end else if (readReq) begin
        rxVal <= canPop;
      end
    end
  end

endmodule

// File: rtl/posrx_port.sv
module posrx_port
  import posrx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrSop,
  input  logic       wrEop,
  input  logic       wrErr,
  input  logic       readEnN,
  input  logic       portSel,
  output logic [7:0] rxData,
  output logic       rxSop,
  output logic       rxEop,
  output logic       rxErr,
  output logic       rxPar,
  output logic       rxVal,
  output logic       tsPulse
);

  rxWord_t wrWord;
  rxStrb_t strb;
  logic    fifoEmpty;
  logic    fifoFull;
  logic    headEop;

  assign wrWord = '{data: wrData, sop: wrSop, eop: wrEop, err: wrErr};

  posrx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .readEnN  (readEnN),
    .portSel  (portSel),
    .fifoEmpty(fifoEmpty),
    .headEop  (headEop),
    .strb     (strb),
    .rxVal    (rxVal)
  );

  posrx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrWord   (wrWord),
    .strb     (strb),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull),
    .headEop  (headEop),
    .rxData   (rxData),
    .rxSop    (rxSop),
    .rxEop    (rxEop),
    .rxErr    (rxErr),
    .rxPar    (rxPar),
    .tsPulse  (tsPulse)
  );

endmodule

// File: rtl/posrx_port_chk.sv
module posrx_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       readEnN,
  input logic       portSel,
  input logic       wrValid,
  input logic       wrSop,
  input logic       fifoFull,
  input logic [7:0] rxData,
  input logic       rxEop,
  input logic       rxErr,
  input logic       rxPar,
  input logic       rxVal,
  input logic       tsPulse
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    readEnN |=> $stable(rxData));

  p_latch_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxVal) && !rxVal && $past(portSel) && portSel) |=> !rxVal);

  p_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    !portSel |=> !rxVal);

  p_err_on_eop_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> rxEop);

  p_odd_parity_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxVal |-> ($countones({rxData, rxPar}) % 2 == 1));

  p_arrival_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSop && !fifoFull) |=> tsPulse);

  p_arrival_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && wrSop) |=> !tsPulse);

endmodule

bind posrx_port posrx_port_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .readEnN (readEnN),
  .portSel (portSel),
  .wrValid (wrValid),
  .wrSop   (wrSop),
  .fifoFull(fifoFull),
  .rxData  (rxData),
  .rxEop   (rxEop),
  .rxErr   (rxErr),
  .rxPar   (rxPar),
  .rxVal   (rxVal),
  .tsPulse (tsPulse)
);

// File: tb/sim_posrx_port.sv
module sim_posrx_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrSop = 1'b0;
  logic       wrEop = 1'b0;
  logic       wrErr = 1'b0;
  logic       readEnN = 1'b1;
  logic       portSel = 1'b0;
  logic [7:0] rxData;
  logic       rxSop;
  logic       rxEop;
  logic       rxErr;
  logic       rxPar;
  logic       rxVal;
  logic       tsPulse;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  posrx_port u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrSop(wrSop), .wrEop(wrEop), .wrErr(wrErr), .readEnN(readEnN),
    .portSel(portSel), .rxData(rxData), .rxSop(rxSop), .rxEop(rxEop),
    .rxErr(rxErr), .rxPar(rxPar), .rxVal(rxVal), .tsPulse(tsPulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Write one tagged byte; check the arrival pulse follows and lasts one cycle.
  task automatic pushByte(input logic [7:0] d, input logic s, input logic e,
                          input logic er, input logic expTs);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrSop = s; wrEop = e; wrErr = er;
    @(negedge clk);
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0; wrErr = 1'b0;
    chk("R9", "tsPulse after write", int'(tsPulse), int'(expTs));
    @(negedge clk);
    chk("R9", "tsPulse one cycle", int'(tsPulse), 0);
  endtask

  // One enabled read cycle; check what appears in the following cycle.
  task automatic readChk(input string req, input logic expVal, input logic [7:0] d,
                         input logic s, input logic e, input logic er);
    readEnN = 1'b0;
    @(negedge clk);
    readEnN = 1'b1;
    chk(req, "rxVal", int'(rxVal), int'(expVal));
    if (expVal) begin
      chk(req, "rxData", int'(rxData), int'(d));
      chk(req, "rxSop", int'(rxSop), int'(s));
      chk(req, "rxEop", int'(rxEop), int'(e));
      chk(req, "rxErr", int'(rxErr), int'(er));
      chk("R8", "rxPar", int'(rxPar), int'(~^d));
    end
  endtask

  task automatic reselect();
    @(negedge clk);
    portSel = 1'b0;
    @(negedge clk);
    chk("R6", "rxVal while deselected", int'(rxVal), 0);
    portSel = 1'b1;
  endtask

  task automatic deselect();
    @(negedge clk);
    portSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1", "rxVal after reset", int'(rxVal), 0);
    chk("R1", "tsPulse after reset", int'(tsPulse), 0);
  endtask

  task automatic testPacketLatch();  // R2, R4
    pushByte(8'h11, 1, 0, 0, 1);
    pushByte(8'h22, 0, 0, 0, 0);
    pushByte(8'h33, 0, 1, 0, 0);
    pushByte(8'h44, 1, 0, 0, 1);
    pushByte(8'h55, 0, 1, 0, 0);
    @(negedge clk);
    portSel = 1'b1;
    readChk("R2", 1, 8'h11, 1, 0, 0);
    readChk("R2", 1, 8'h22, 0, 0, 0);
    readChk("R2", 1, 8'h33, 0, 1, 0);
    readChk("R4", 0, 8'h00, 0, 0, 0);
    readChk("R4", 0, 8'h00, 0, 0, 0);
    reselect();
    readChk("R4", 1, 8'h44, 1, 0, 0);
    readChk("R4", 1, 8'h55, 0, 1, 0);
    readChk("R4", 0, 8'h00, 0, 0, 0);
    deselect();
  endtask

  task automatic testHold();  // R3
    pushByte(8'h66, 1, 0, 0, 1);
    pushByte(8'h77, 0, 1, 0, 0);
    @(negedge clk);
    portSel = 1'b1;
    readChk("R2", 1, 8'h66, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3", "rxData held", int'(rxData), 8'h66);
      chk("R3", "rxVal held", int'(rxVal), 1);
    end
    readChk("R3", 1, 8'h77, 0, 1, 0);
    readChk("R4", 0, 8'h00, 0, 0, 0);
    deselect();
  endtask

  task automatic testEmpty();  // R1, R5
    @(negedge clk);
    portSel = 1'b1;
    readChk("R1", 0, 8'h00, 0, 0, 0);
    pushByte(8'h88, 1, 1, 0, 1);
    readChk("R5", 0, 8'h00, 0, 0, 0);
    reselect();
    readChk("R5", 1, 8'h88, 1, 1, 0);
    readChk("R5", 0, 8'h00, 0, 0, 0);
    deselect();
  endtask

  task automatic testDeselected();  // R6
    pushByte(8'h9C, 1, 1, 0, 1);
    @(negedge clk);
    readEnN = 1'b0;
    @(negedge clk);
    chk("R6", "rxVal unselected read", int'(rxVal), 0);
    @(negedge clk);
    chk("R6", "rxVal unselected read", int'(rxVal), 0);
    readEnN = 1'b1;
    portSel = 1'b1;
    readChk("R6", 1, 8'h9C, 1, 1, 0);
    deselect();
  endtask

  task automatic testError();  // R7
    pushByte(8'h5A, 1, 0, 1, 1);
    pushByte(8'hA5, 0, 1, 1, 0);
    @(negedge clk);
    portSel = 1'b1;
    readChk("R7", 1, 8'h5A, 1, 0, 0);
    readChk("R7", 1, 8'hA5, 0, 1, 1);
    deselect();
  endtask

  task automatic testParity();  // R8
    pushByte(8'h00, 1, 0, 0, 1);
    pushByte(8'hFF, 0, 0, 0, 0);
    pushByte(8'h01, 0, 1, 0, 0);
    @(negedge clk);
    portSel = 1'b1;
    readChk("R8", 1, 8'h00, 1, 0, 0);
    chk("R8", "rxPar of 00", int'(rxPar), 1);
    readChk("R8", 1, 8'hFF, 0, 0, 0);
    chk("R8", "rxPar of FF", int'(rxPar), 1);
    readChk("R8", 1, 8'h01, 0, 1, 0);
    chk("R8", "rxPar of 01", int'(rxPar), 0);
    deselect();
  endtask

  task automatic testFull();  // R10
    for (int i = 0; i < 17; i++) begin
      pushByte(8'(8'hC0 + i), (i == 0 || i == 16), 0, 0, (i == 0));
    end
    @(negedge clk);
    portSel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      readChk("R10", 1, 8'(8'hC0 + i), (i == 0), 0, 0);
    end
    readChk("R10", 0, 8'h00, 0, 0, 0);
    deselect();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nRun++;
        nFail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPacketLatch();
    testHold();
    testEmpty();
    testDeselected();
    testError();
    testParity();
    testFull();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule